// File: doc/BRIEF.md
# Embedded-Sync Byte Stream Formatter for 4:2:2 Video

This block turns 4:2:2 YCbCr pixel pairs into an 8-bit byte stream with embedded timing reference codes, as used on parallel digital video links. It runs on a clock at twice the pixel sample rate and emits one byte after every rising edge. Each line begins with an end-of-active-video code. Horizontal blanking filled with neutral black follows. A start-of-active-video code comes next, and then exactly 1440 active bytes close the line.

Software or an upstream timing unit programs the total line length per line: nominally 1716 bytes for 525-line systems and 1728 for 625-line systems. It also programs the frame length, the line where the second field begins, and the active line range of each field. A line that is longer or shorter than nominal changes only the horizontal blanking fill. The active span never moves relative to the line end and never changes length. The pixel source watches `pix_take` and presents a chroma/luma pair in that cycle. Chroma alternates Cb, Cr across pairs as supplied by the source, so active bytes leave in the order Cb, Y, Cr, Y.

Top module: `bt656_stream_fmt`

## Requirements
- R1: The line length is `line_total` as sampled on the clock edge that emits the line's first byte. Byte positions within a line run 0 .. length-1, and a new line starts after position length-1.
- R2: Positions 0..3 of every line carry FF, 00, 00, XY with the H bit (XY bit 4) set to 1.
- R3: The four positions just before the active span carry FF, 00, 00, XY with H = 0.
- R4: XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, bit 7 first.
- R5: The last 1440 positions of a line form the active span. On a line with V = 0, `pix_take` is high exactly in the cycles whose next byte is at an even offset into the span. The sampled `pix_c` goes out on the next byte and the sampled `pix_y` on the byte after.
- R6: An active pixel byte of 0x00 goes out as 0x01, and a byte of 0xFF goes out as 0xFE. Other values pass unchanged.
- R7: The blanking fill between the codes is 0x80 at even positions and 0x10 at odd positions. On a line with V = 1 the active span carries no pixels: `pix_take` stays low, and the span holds 0x80 at even offsets and 0x10 at odd offsets.
- R8: For line number n (0 at frame start), F = 1 when n >= `field2_line`. V = 0 when n lies within `act0_first..act0_last` or within `act1_first..act1_last`, and V = 1 otherwise. The frame wraps after line `frame_lines`-1. `vsync` and `field` show V and F alongside every byte of the line.
- R9: `blank` is low only on active pixel bytes of lines with V = 0. `hsync` is high on the first 128 bytes of each line.
- R10: A `line_total` below 1452 is treated as 1452.
- R11: While reset is held, `bt_byte` is 0x10, `blank` is 1, and `hsync`, `vsync`, `field` and `pix_take` are 0. The first byte after reset is position 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_total | input | 11 | Total bytes in the next line |
| frame_lines | input | 10 | Lines per frame |
| field2_line | input | 10 | First line of the second field |
| act0_first | input | 10 | First active line of field one |
| act0_last | input | 10 | Last active line of field one |
| act1_first | input | 10 | First active line of field two |
| act1_last | input | 10 | Last active line of field two |
| pix_c | input | 8 | Chroma byte of the pair being taken |
| pix_y | input | 8 | Luma byte of the pair being taken |
| pix_take | output | 1 | Pixel pair sampled at this edge |
| bt_byte | output | 8 | Output stream byte |
| blank | output | 1 | Byte is not an active pixel |
| hsync | output | 1 | Horizontal sync window |
| vsync | output | 1 | Vertical blanking flag of the current line |
| field | output | 1 | Field flag of the current line |

## Verification
Every stream byte and its side flags are registered, so they appear one edge after the state that chose them. The bench samples on the falling edge and checks them against the line position its own model holds for that edge. A pixel pair taken at one edge shows up as chroma after the next edge and as luma one edge later. The bench therefore drives a pair on the falling edge where `pix_take` is high, and it compares the following two falling-edge samples against that pair. `line_total` and the vertical settings change only on the falling edge before a line's first byte, which is exactly when the design samples them.

// File: rtl/bt656_stream_fmt.sv
module bt656_stream_fmt #(
  parameter int ACT  = 1440,
  parameter int HW   = 11,
  parameter int VW   = 10,
  parameter int HS_W = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] line_total,
  input  logic [VW-1:0] frame_lines,
  input  logic [VW-1:0] field2_line,
  input  logic [VW-1:0] act0_first,
  input  logic [VW-1:0] act0_last,
  input  logic [VW-1:0] act1_first,
  input  logic [VW-1:0] act1_last,
  input  logic [7:0]    pix_c,
  input  logic [7:0]    pix_y,
  output logic          pix_take,
  output logic [7:0]    bt_byte,
  output logic          blank,
  output logic          hsync,
  output logic          vsync,
  output logic          field
);

  localparam logic [HW-1:0] MIN_L = HW'(ACT + 12);
  localparam logic [HW-1:0] ACT_L = HW'(ACT);
  localparam logic [HW-1:0] HS_L  = HW'(HS_W);

  logic [HW-1:0] h, len;
  logic [VW-1:0] v;
  logic [7:0]    y_hold, nxt;

  function automatic logic [7:0] clamp(input logic [7:0] b);
    if (b == 8'h00) return 8'h01;
    if (b == 8'hFF) return 8'hFE;
    return b;
  endfunction

  wire [HW-1:0] len_eff = (line_total < MIN_L) ? MIN_L : line_total;
  wire [HW-1:0] act_pos = len - ACT_L;
  wire [HW-1:0] sav_pos = act_pos - HW'(4);
  wire [HW-1:0] off     = h - act_pos;
  wire [HW-1:0] soff    = h - sav_pos;
  wire          in_eav  = (h < HW'(4));
  wire          in_sav  = !in_eav && (h >= sav_pos) && (h < act_pos);
  wire          in_act  = !in_eav && (h >= act_pos);
  wire          last    = (h == len - HW'(1));

  wire f_now = (v >= field2_line);
  wire v_now = !(((v >= act0_first) && (v <= act0_last)) ||
                 ((v >= act1_first) && (v <= act1_last)));
  wire hb    = in_eav;
  wire [7:0] xy = {1'b1, f_now, v_now, hb, v_now ^ hb, f_now ^ hb, f_now ^ v_now, f_now ^ v_now ^ hb};
  wire [1:0] k  = in_eav ? h[1:0] : soff[1:0];
  wire [7:0] code = (k == 2'd0) ? 8'hFF : (k == 2'd3) ? xy : 8'h00;

  assign pix_take = in_act && !v_now && !off[0];

  always_comb begin
    if (in_eav || in_sav)   nxt = code;
    else if (in_act)        nxt = v_now ? (off[0] ? 8'h10 : 8'h80)
                                        : (off[0] ? clamp(y_hold) : clamp(pix_c));
    else                    nxt = h[0] ? 8'h10 : 8'h80;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h <= '0;
      v <= '0;
      len <= MIN_L;
      y_hold <= 8'h10;
      bt_byte <= 8'h10;
      blank <= 1'b1;
      hsync <= 1'b0;
      vsync <= 1'b0;
      field <= 1'b0;
    end else begin
      if (h == '0) len <= len_eff;
      if (pix_take) y_hold <= pix_y;
      if (h != '0 && last) begin
        h <= '0;
        v <= (v >= frame_lines - VW'(1)) ? '0 : v + VW'(1);
      end else begin
        h <= h + HW'(1);
      end
      bt_byte <= nxt;
      blank <= !(in_act && !v_now);
      hsync <= (h < HS_L);
      vsync <= v_now;
      field <= f_now;
    end
  end

  assert_pos_in_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (h != '0) |-> (h < len));

  assert_xy_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bt_byte, 3) == 8'hFF && $past(bt_byte, 2) == 8'h00 && $past(bt_byte, 1) == 8'h00)
    |-> (bt_byte[7] && bt_byte[3:0] == {bt_byte[5] ^ bt_byte[4], bt_byte[6] ^ bt_byte[4],
                                        bt_byte[6] ^ bt_byte[5], ^bt_byte[6:4]}));

  assert_take_then_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take |=> (!blank ##1 !blank));

  assert_no_code_in_pixels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> (bt_byte != 8'h00 && bt_byte != 8'hFF));

  assert_flags_change_at_eav_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field) || vsync != $past(vsync)) |-> (bt_byte == 8'hFF && hsync));

endmodule

// File: tb/test_bt656_stream_fmt.sv
module test_bt656_stream_fmt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [10:0] line_total;
  logic [9:0]  frame_lines, field2_line, act0_first, act0_last, act1_first, act1_last;
  logic [7:0]  pix_c = 8'h00, pix_y = 8'h00;
  logic        pix_take, blank, hsync, vsync, field;
  logic [7:0]  bt_byte;

  int vectors = 0, errors = 0;
  int bpos, bline, blen;
  logic [7:0] pc, py;

  always #2.5 clk = ~clk;

  bt656_stream_fmt i_bt656_stream_fmt (
    .clk, .rst_n, .line_total, .frame_lines, .field2_line, .act0_first, .act0_last,
    .act1_first, .act1_last, .pix_c, .pix_y, .pix_take, .bt_byte, .blank, .hsync,
    .vsync, .field);

  function automatic int eff(input int t);
    return (t < 1452) ? 1452 : t;
  endfunction

  function automatic logic lineV(input int n);
    return !((n >= act0_first && n <= act0_last) || (n >= act1_first && n <= act1_last));
  endfunction

  function automatic logic lineF(input int n);
    return n >= field2_line;
  endfunction

  function automatic logic [7:0] xy_of(input logic f, input logic vv, input logic hh);
    return {1'b1, f, vv, hh, vv ^ hh, f ^ hh, f ^ vv, f ^ vv ^ hh};
  endfunction

  function automatic logic [7:0] clampb(input logic [7:0] b);
    return (b == 8'h00) ? 8'h01 : (b == 8'hFF) ? 8'hFE : b;
  endfunction

  function automatic logic [7:0] exp_byte(input int p, input int n, input int L);
    int a = L - 1440;
    logic f = lineF(n), vv = lineV(n);
    if (p < 4)
      return (p == 0) ? 8'hFF : (p == 3) ? xy_of(f, vv, 1'b1) : 8'h00;
    if (p >= a - 4 && p < a)
      return (p == a - 4) ? 8'hFF : (p == a - 1) ? xy_of(f, vv, 1'b0) : 8'h00;
    if (p >= a) begin
      if (vv) return ((p - a) % 2) ? 8'h10 : 8'h80;
      return ((p - a) % 2) ? clampb(py) : clampb(pc);
    end
    return (p % 2) ? 8'h10 : 8'h80;
  endfunction

  function automatic string tag_of(input int p, input int L);
    int a = L - 1440;
    if (p == 0) return (L == 1452) ? "R10" : "R1";
    if (p == 3 || p == a - 1) return "R4";
    if (p < 4) return "R2";
    if (p >= a - 4 && p < a) return "R3";
    if (p >= a) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d line=%0d actual=%h expected=%h", req, bpos, bline, act, exp);
    end
  endtask

  task automatic set_std(input int fl, input int f2, input int a0, input int b0, input int a1, input int b1);
    frame_lines = 10'(fl); field2_line = 10'(f2);
    act0_first = 10'(a0); act0_last = 10'(b0);
    act1_first = 10'(a1); act1_last = 10'(b1);
  endtask

  task automatic run_frames(input int nominal, input int frames);
    int lines_done = 0;
    int total = frames * int'(frame_lines);
    while (lines_done < total) begin
      @(posedge clk); @(negedge clk);
      chk(tag_of(bpos, blen), 32'(bt_byte), 32'(exp_byte(bpos, bline, blen)));
      chk("R9", 32'({blank, hsync}),
          32'({!(bpos >= blen - 1440 && !lineV(bline)), 1'b0 | (bpos < 128)}));
      chk("R8", 32'({vsync, field}), 32'({lineV(bline), lineF(bline)}));
      if (bpos == blen - 1) begin
        bpos = 0;
        lines_done++;
        bline = (bline == int'(frame_lines) - 1) ? 0 : bline + 1;
        if (lines_done == 3) line_total = 11'd900;
        else line_total = 11'(nominal + int'($urandom_range(0, 12)) - 6);
        blen = eff(int'(line_total));
      end else begin
        bpos++;
      end
      chk("R5", 32'(pix_take),
          32'(bpos >= blen - 1440 && bpos >= 4 && !lineV(bline) && ((bpos - (blen - 1440)) % 2 == 0)));
      if (pix_take) begin
        case ($urandom_range(0, 7))
          0: begin pc = 8'h00; py = 8'hFF; end
          1: begin pc = 8'hFF; py = 8'h00; end
          2: begin pc = 8'h01; py = 8'hFE; end
          default: begin pc = 8'($urandom); py = 8'($urandom); end
        endcase
        pix_c = pc; pix_y = py;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd656));
    line_total = 11'd1716;
    set_std(10, 5, 2, 3, 7, 8);
    repeat (3) @(negedge clk);
    chk("R11", 32'({bt_byte, blank, hsync, vsync, field, pix_take}), 32'({8'h10, 5'b10000}));
    rst_n = 1'b1;
    bpos = 0; bline = 0; blen = eff(int'(line_total));
    run_frames(1716, 2);
    set_std(8, 4, 1, 2, 5, 6);
    line_total = 11'd1728;
    blen = eff(int'(line_total));
    run_frames(1728, 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule